// File: doc/BRIEF.md
# Run-Length Frame Opcode Decoder

This block expands a byte stream of run-length opcodes into a stream of 4-bit palette indices for a 64x64 frame. One kind of opcode picks the current colour. Two other kinds repeat that colour: one counts in single pixels and the other counts in blocks of sixteen pixels. Opcodes arrive on a valid/ready byte port. Pixels leave on a valid/ready port at up to one pixel per cycle. The pixel port carries a flag on the final pixel of each frame.

The decoder keeps a count of the pixels emitted in the current frame. When the frame is complete, it raises a one-cycle frame-done pulse, resets the colour to index 0 and begins the next frame. Malformed input sets sticky status flags, which clear only at reset:
- an out-of-range colour,
- an unknown opcode class,
- a run with no colour chosen,
- a run that crosses the frame boundary.

A finite-state machine with three states controls the block:
- `ST_FETCH` accepts opcodes.
- `ST_EMIT` drives the pixels of one run.
- `ST_FLUSH` closes a frame.

The transitions are:
- fetch-to-emit, taken on an accepted run opcode;
- emit-to-fetch, taken on the last pixel of a run inside the frame;
- emit-to-flush, taken on the final pixel of the frame;
- flush-to-fetch, taken unconditionally.

Colour opcodes and rejected opcodes keep the machine in `ST_FETCH`.

Top module: `rle_frame_decoder`

## Requirements
- R1: After reset, `op_ready` is 1 and `pix_valid`, `pix_last`, `frame_done` and all four status flags are 0.
- R2: An accepted opcode `0x0C` with C below 13 makes C the current colour. It emits no pixel, and `op_ready` is high again in the next cycle.
- R3: An accepted opcode `0x2N` emits N+1 pixels carrying the current colour on `pix_index`.
- R4: An accepted opcode `0x3N` emits (N+1)*16 pixels of the current colour. Successive run opcodes with no colour opcode between them keep the same colour.
- R5: `op_ready` stays low from the cycle after a run opcode is accepted until its last pixel has been taken, so it is never high at the same time as `pix_valid`.
- R6: While `pix_ready` is low, `pix_valid`, `pix_index` and `pix_last` hold their values and no pixel is lost or repeated.
- R7: `pix_last` is high on exactly the 4096th pixel of a frame. `frame_done` pulses high for one cycle in the cycle after that pixel is taken, with `op_ready` low during the pulse. The next frame then starts at pixel 0 with colour 0.
- R8: A colour opcode `0x0D` to `0x0F` sets `err_color` and leaves the current colour unchanged. `pix_index` never exceeds 12.
- R9: An opcode whose upper nibble is not 0x0, 0x2 or 0x3 sets `err_opcode`. It has no other effect: no pixel is emitted and `op_ready` stays high.
- R10: A run opcode accepted before any colour opcode in the current frame emits colour 0 and sets `warn_nocolor`.
- R11: A run that would go past pixel 4096 is cut at the frame boundary. The rest of the run is dropped and `err_overflow` is set. Flags in R8 to R11 stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode byte present |
| op_data | input | 8 | Opcode byte: upper nibble class, lower nibble argument |
| op_ready | output | 1 | Decoder accepts an opcode this cycle |
| pix_valid | output | 1 | Pixel present on `pix_index` |
| pix_index | output | 4 | Palette index of the pixel |
| pix_last | output | 1 | Pixel is the last one of the frame |
| pix_ready | input | 1 | Consumer takes the pixel this cycle |
| frame_done | output | 1 | One-cycle pulse after a frame's last pixel |
| err_color | output | 1 | Sticky: colour argument out of range |
| err_opcode | output | 1 | Sticky: unknown opcode class |
| warn_nocolor | output | 1 | Sticky: run before any colour in a frame |
| err_overflow | output | 1 | Sticky: run cut at the frame boundary |

## Verification
The opcode properties look only at cycles where `op_valid` and `op_ready` are both high, so they assume nothing about `op_data` at other times. The hold property assumes the consumer may stall for any number of cycles. The frame-position property counts handshakes from reset, so it assumes reset is applied before the first opcode. The stimulus drives inputs only at falling edges, holds each opcode until it is accepted and drops `op_valid` right after. It mixes random run, colour and illegal opcodes with random stalls on `pix_ready`, and only ever leaves the input unchanged or starts a fresh handshake.

// File: rtl/rle_dec_pkg.sv
package rle_dec_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EMIT  = 2'd1,
        ST_FLUSH = 2'd2
    } dec_state_t;

    // Opcode classes after decoding the upper nibble
    typedef enum logic [1:0] {
        OPK_COLOR = 2'd0,
        OPK_SHORT = 2'd1,
        OPK_LONG  = 2'd2,
        OPK_BAD   = 2'd3
    } op_kind_t;

    // Upper-nibble codes the decoder understands
    localparam logic [3:0] HI_COLOR = 4'h0;
    localparam logic [3:0] HI_SHORT = 4'h2;
    localparam logic [3:0] HI_LONG  = 4'h3;

endpackage

// File: rtl/rle_op_classify.sv
module rle_op_classify
    import rle_dec_pkg::*;
#(
    parameter int NUM_COLORS = 13,
    parameter int LONG_UNIT  = 16,
    parameter int RUN_W      = 9
) (
    input  logic [7:0]       op,
    output op_kind_t         kind,
    output logic [RUN_W-1:0] run_len,
    output logic [3:0]       color,
    output logic             color_ok
);

    logic [3:0] arg;

    assign arg = op[3:0];

    always_comb begin
        color    = arg;
        color_ok = (int'(arg) < NUM_COLORS);
        run_len  = '0;
        unique case (op[7:4])
            HI_COLOR: begin
                kind = OPK_COLOR;
            end
            HI_SHORT: begin
                kind    = OPK_SHORT;
                run_len = RUN_W'(arg) + RUN_W'(1);
            end
            HI_LONG: begin
                kind    = OPK_LONG;
                run_len = RUN_W'((int'(arg) + 1) * LONG_UNIT);
            end
            default: begin
                kind = OPK_BAD;
            end
        endcase
    end

endmodule

// File: rtl/rle_run_counter.sv
module rle_run_counter #(
    parameter int RUN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RUN_W-1:0] load_val,
    input  logic             step,
    input  logic             clear,
    output logic             last_one
);

    logic [RUN_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (clear) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (step && remain_q != '0) begin
            remain_q <= remain_q - RUN_W'(1);
        end
    end

    assign last_one = (remain_q == RUN_W'(1));

endmodule

// File: rtl/rle_pixel_counter.sv
module rle_pixel_counter #(
    parameter int FRAME_PIXELS = 4096,
    parameter int PIX_W        = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic at_end
);

    logic [PIX_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clear) begin
            pos_q <= '0;
        end else if (step && !at_end) begin
            pos_q <= pos_q + PIX_W'(1);
        end
    end

    assign at_end = (pos_q == PIX_W'(FRAME_PIXELS - 1));

endmodule

// File: rtl/rle_frame_decoder.sv
module rle_frame_decoder
    import rle_dec_pkg::*;
#(
    parameter int FRAME_PIXELS = 4096,
    parameter int NUM_COLORS   = 13,
    parameter int LONG_UNIT    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [7:0] op_data,
    output logic       op_ready,
    output logic       pix_valid,
    output logic [3:0] pix_index,
    output logic       pix_last,
    input  logic       pix_ready,
    output logic       frame_done,
    output logic       err_color,
    output logic       err_opcode,
    output logic       warn_nocolor,
    output logic       err_overflow
);

    localparam int RUN_MAX = 16 * LONG_UNIT;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam int PIX_W   = (FRAME_PIXELS > 1) ? $clog2(FRAME_PIXELS) : 1;

    dec_state_t       state_q, state_d;
    op_kind_t         kind;
    logic [RUN_W-1:0] run_len;
    logic [3:0]       arg_color;
    logic             color_ok;
    logic             op_fire, pix_fire, is_run;
    logic             run_last, frame_end;
    logic [3:0]       color_q;
    logic             seen_q;
    logic             ecol_q, eop_q, warn_q, ovf_q;

    // Opcode decoding
    rle_op_classify #(
        .NUM_COLORS(NUM_COLORS),
        .LONG_UNIT (LONG_UNIT),
        .RUN_W     (RUN_W)
    ) u_classify (
        .op      (op_data),
        .kind    (kind),
        .run_len (run_len),
        .color   (arg_color),
        .color_ok(color_ok)
    );

    assign op_fire  = op_valid && op_ready;
    assign pix_fire = pix_valid && pix_ready;
    assign is_run   = (kind == OPK_SHORT) || (kind == OPK_LONG);

    // Remaining pixels of the run in progress
    rle_run_counter #(
        .RUN_W(RUN_W)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (op_fire && is_run),
        .load_val(run_len),
        .step    (pix_fire),
        .clear   (state_q == ST_FLUSH),
        .last_one(run_last)
    );

    // Position inside the frame
    rle_pixel_counter #(
        .FRAME_PIXELS(FRAME_PIXELS),
        .PIX_W       (PIX_W)
    ) u_pix (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (pix_fire),
        .clear (state_q == ST_FLUSH),
        .at_end(frame_end)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: begin
                if (op_fire && is_run) begin
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (pix_fire) begin
                    if (frame_end) begin
                        state_d = ST_FLUSH;
                    end else if (run_last) begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_FLUSH: begin
                state_d = ST_FETCH;
            end
            default: begin
                state_d = ST_FETCH;
            end
        endcase
    end

    // Moore outputs of the controller
    always_comb begin
        op_ready   = 1'b0;
        pix_valid  = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            ST_FETCH: op_ready   = 1'b1;
            ST_EMIT:  pix_valid  = 1'b1;
            ST_FLUSH: frame_done = 1'b1;
            default:  op_ready   = 1'b0;
        endcase
        pix_last  = pix_valid && frame_end;
        pix_index = color_q;
    end

    // Colour register and per-frame colour-seen marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            color_q <= '0;
            seen_q  <= 1'b0;
        end else if (state_q == ST_FLUSH) begin
            color_q <= '0;
            seen_q  <= 1'b0;
        end else if (op_fire && kind == OPK_COLOR && color_ok) begin
            color_q <= arg_color;
            seen_q  <= 1'b1;
        end
    end

    // Sticky status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecol_q <= 1'b0;
            eop_q  <= 1'b0;
            warn_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (op_fire && kind == OPK_COLOR && !color_ok) begin
                ecol_q <= 1'b1;
            end
            if (op_fire && kind == OPK_BAD) begin
                eop_q <= 1'b1;
            end
            if (op_fire && is_run && !seen_q) begin
                warn_q <= 1'b1;
            end
            if (state_q == ST_EMIT && pix_fire && frame_end && !run_last) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign err_color    = ecol_q;
    assign err_opcode   = eop_q;
    assign warn_nocolor = warn_q;
    assign err_overflow = ovf_q;

endmodule

// File: rtl/rle_frame_decoder_chk.sv
module rle_frame_decoder_chk #(
    parameter int FRAME_PIXELS = 4096,
    parameter int NUM_COLORS   = 13
) (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [7:0] op_data,
    input logic       op_ready,
    input logic       pix_valid,
    input logic [3:0] pix_index,
    input logic       pix_last,
    input logic       pix_ready,
    input logic       frame_done,
    input logic       err_color,
    input logic       err_opcode,
    input logic       warn_nocolor,
    input logic       err_overflow
);

    localparam int CW = $clog2(FRAME_PIXELS) + 1;

    logic [CW-1:0] seen_pix;
    logic          op_fire;
    logic          hs_color, hs_run, hs_bad;

    assign op_fire  = op_valid && op_ready;
    assign hs_color = op_fire && (op_data[7:4] == 4'h0);
    assign hs_run   = op_fire && (op_data[7:4] == 4'h2 || op_data[7:4] == 4'h3);
    assign hs_bad   = op_fire && !(op_data[7:4] == 4'h0 || op_data[7:4] == 4'h2
                                   || op_data[7:4] == 4'h3);

    // Independent count of pixels taken in the current frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_pix <= '0;
        end else if (pix_valid && pix_ready) begin
            seen_pix <= pix_last ? '0 : seen_pix + CW'(1);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> op_ready && !pix_valid && !frame_done); // R1
    AST_COLOR_NO_PIX: assert property (@(posedge clk) disable iff (!rst_n) hs_color |=> op_ready && !pix_valid); // R2
    AST_RUN_STARTS: assert property (@(posedge clk) disable iff (!rst_n) hs_run |=> pix_valid); // R3
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(op_ready && pix_valid)); // R5
    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) pix_valid && !pix_ready |=> pix_valid && $stable(pix_index) && $stable(pix_last)); // R6
    AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n) pix_valid && pix_last |-> seen_pix == CW'(FRAME_PIXELS - 1)); // R7
    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) pix_valid && pix_ready && pix_last |=> frame_done && !op_ready); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done && op_ready); // R7
    AST_BAD_COLOR: assert property (@(posedge clk) disable iff (!rst_n) hs_color && int'(op_data[3:0]) >= NUM_COLORS |=> err_color); // R8
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |-> int'(pix_index) < NUM_COLORS); // R8
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n) hs_bad |=> err_opcode && op_ready && !pix_valid); // R9
    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) warn_nocolor |=> warn_nocolor); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_overflow |=> err_overflow); // R11

endmodule

bind rle_frame_decoder rle_frame_decoder_chk #(
    .FRAME_PIXELS(FRAME_PIXELS),
    .NUM_COLORS  (NUM_COLORS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_data     (op_data),
    .op_ready    (op_ready),
    .pix_valid   (pix_valid),
    .pix_index   (pix_index),
    .pix_last    (pix_last),
    .pix_ready   (pix_ready),
    .frame_done  (frame_done),
    .err_color   (err_color),
    .err_opcode  (err_opcode),
    .warn_nocolor(warn_nocolor),
    .err_overflow(err_overflow)
);

// File: tb/sim_rle_frame_decoder.sv
module sim_rle_frame_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 4096;
    localparam int NCOL       = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_data = 8'h00;
    logic       op_ready;
    logic       pix_valid;
    logic [3:0] pix_index;
    logic       pix_last;
    logic       pix_ready = 1'b0;
    logic       frame_done;
    logic       err_color, err_opcode, warn_nocolor, err_overflow;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rle_frame_decoder u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_data     (op_data),
        .op_ready    (op_ready),
        .pix_valid   (pix_valid),
        .pix_index   (pix_index),
        .pix_last    (pix_last),
        .pix_ready   (pix_ready),
        .frame_done  (frame_done),
        .err_color   (err_color),
        .err_opcode  (err_opcode),
        .warn_nocolor(warn_nocolor),
        .err_overflow(err_overflow)
    );

    typedef struct packed {
        logic [3:0] idx;
        logic       last;
    } pix_t;

    int   checks = 0;
    int   fails  = 0;
    pix_t exp_q[$];

    // Reference model state
    logic [3:0] m_color = 4'd0;
    bit   m_seen = 1'b0;
    int   m_cnt  = 0;
    bit   m_ecol = 1'b0, m_eop = 1'b0, m_warn = 1'b0, m_ovf = 1'b0;

    bit stall_hold = 1'b0;
    bit rnd_ready  = 1'b0;
    bit pend_done  = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected effect of one accepted opcode
    task automatic model_apply(input logic [7:0] op);
        int hi;
        int lo;
        int len;
        hi = int'(op[7:4]);
        lo = int'(op[3:0]);
        if (hi == 0) begin
            if (lo < NCOL) begin
                m_color = op[3:0];
                m_seen  = 1'b1;
            end else begin
                m_ecol = 1'b1;
            end
        end else if (hi == 2 || hi == 3) begin
            len = (hi == 2) ? lo + 1 : (lo + 1) * 16;
            if (!m_seen) m_warn = 1'b1;
            for (int i = 0; i < len; i++) begin
                exp_q.push_back(pix_t'{m_color, (m_cnt == FRAME - 1)});
                if (m_cnt == FRAME - 1) begin
                    if (i < len - 1) m_ovf = 1'b1;
                    m_cnt   = 0;
                    m_color = 4'd0;
                    m_seen  = 1'b0;
                    break;
                end
                m_cnt++;
            end
        end else begin
            m_eop = 1'b1;
        end
    endtask

    task automatic send(input logic [7:0] op);
        @(negedge clk);
        op_valid = 1'b1;
        op_data  = op;
        while (!op_ready) @(negedge clk);
        @(posedge clk);
        model_apply(op);
        #1;
        op_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_q.size() != 0 || !op_ready) @(negedge clk);
    endtask

    // Emit n pixels of the current colour using run opcodes
    task automatic fill(input int n);
        int rem;
        rem = n;
        while (rem >= 256) begin
            send(8'h3F);
            rem -= 256;
        end
        if (rem >= 16) begin
            send(8'h30 | 8'(rem / 16 - 1));
            rem = rem % 16;
        end
        if (rem > 0) send(8'h20 | 8'(rem - 1));
    endtask

    task automatic check_flags();
        chk("R8 err_color", int'(err_color), int'(m_ecol));
        chk("R9 err_opcode", int'(err_opcode), int'(m_eop));
        chk("R10 warn_nocolor", int'(warn_nocolor), int'(m_warn));
        chk("R11 err_overflow", int'(err_overflow), int'(m_ovf));
    endtask

    // Pixel consumer and output monitor
    always @(negedge clk) begin
        pix_t e;
        if (!rst_n) begin
            pix_ready = 1'b0;
        end else begin
            chk("R7 frame_done", int'(frame_done), int'(pend_done));
            pend_done = 1'b0;
            pix_ready = stall_hold ? 1'b0 : (rnd_ready ? (($urandom % 4) != 0) : 1'b1);
            if (pix_valid && pix_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected pixel", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R3 pix_index", int'(pix_index), int'(e.idx));
                    chk("R7 pix_last", int'(pix_last), int'(e.last));
                    if (e.last) pend_done = 1'b1;
                end
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: actual 200000 cycles expected completion");
        finish_run();
    end

    initial begin
        int dummy;
        int r;
        logic [3:0] hi;
        dummy = int'($urandom(32'd20250611));

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 op_ready in reset", int'(op_ready), 1);
        chk("R1 pix_valid in reset", int'(pix_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 op_ready", int'(op_ready), 1);
        chk("R1 pix_valid", int'(pix_valid), 0);
        chk("R1 frame_done", int'(frame_done), 0);
        check_flags();

        // R2: colour opcode emits nothing, ready again next cycle
        send(8'h05);
        @(negedge clk);
        chk("R2 op_ready after colour", int'(op_ready), 1);
        chk("R2 pix_valid after colour", int'(pix_valid), 0);

        // R3, R4: short and long runs continue the colour
        send(8'h23);
        send(8'h31);
        send(8'h2F);
        @(negedge clk);
        chk("R5 op_ready low during run", int'(op_ready), 0);
        drain();

        // R6: backpressure holds the pixel
        send(8'h07);
        send(8'h2F);
        stall_hold = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R6 pix_valid held", int'(pix_valid), 1);
            chk("R6 pix_index held", int'(pix_index), 7);
            chk("R5 op_ready low while stalled", int'(op_ready), 0);
        end
        #1 stall_hold = 1'b0;
        drain();

        // R8: out-of-range colour keeps the old colour
        send(8'h0E);
        send(8'h22);
        drain();
        check_flags();

        // R9: unknown opcode classes are ignored
        send(8'h47);
        send(8'hF0);
        @(negedge clk);
        chk("R9 op_ready after bad op", int'(op_ready), 1);
        chk("R9 pix_valid after bad op", int'(pix_valid), 0);
        drain();
        check_flags();

        // R7: complete the frame exactly, under random stalls
        rnd_ready = 1'b1;
        send(8'h0B);
        fill(FRAME - m_cnt);
        drain();
        check_flags();

        // R10: run before any colour in the new frame
        send(8'h24);
        drain();
        check_flags();

        // R11: run crossing the frame boundary
        send(8'h03);
        fill(FRAME - m_cnt - 6);
        send(8'h2F);
        send(8'h05);
        send(8'h21);
        drain();
        check_flags();

        // Random opcode mix
        for (int k = 0; k < 800; k++) begin
            r = int'($urandom % 100);
            if (r < 25) begin
                send(8'(($urandom % 16)));
            end else if (r < 55) begin
                send(8'h20 | 8'($urandom % 16));
            end else if (r < 95) begin
                send(8'h30 | 8'($urandom % 16));
            end else begin
                hi = (($urandom % 2) != 0) ? 4'h1 : 4'(4 + ($urandom % 12));
                send({hi, 4'($urandom % 16)});
            end
        end
        drain();
        check_flags();

        finish_run();
    end

endmodule